// File: doc/BRIEF.md
# Spare-Core Index Remapper

This block sits between the core array of a chip and the software-visible numbering of its processors. The array carries N_LOG + 1 physical cores (by default 18: sixteen compute cores, one service core and one spare). Exactly one physical core is always switched off. Either it is the core marked as failed in a defect record, or it is the spare when no core failed. The remaining N_LOG cores are numbered 0 to N_LOG-1 without gaps.

After reset the block takes a 6-bit defect record, one bit per strobe, from on-chip fuse storage. When the record is complete it fixes the disabled core and drives one enable per physical core. It also serves two combinational lookups. The first turns a logical ID into a physical index. The second turns a physical index into a logical ID and flags when no logical core exists for it. A physical core below the disabled one keeps its number. A physical core above it takes its own number minus one.

Top module: `redun_remap`

## Requirements
- R1: While reset is applied and just after it, `load_done_o` is low, `fuse_err_o` is low, every bit of `core_en_o` is low, and both lookup ok flags are low with zero result values.
- R2: A record is six bits, each taken on a rising clock edge where `fuse_vld_i` is high. The first bit is the record-present flag. The next five are the failed index, least significant bit first. `load_done_o` is still low after five strobes and is high from the edge that takes the sixth.
- R3: Once `load_done_o` is high, further strobes have no effect on `core_en_o`, `fuse_err_o` or the lookups until the next reset.
- R4: A present record whose index is in 0..N_LOG clears only that index's enable bit and sets all other enables.
- R5: A record whose present flag is 0 disables physical core N_LOG, whatever its index bits hold, and leaves `fuse_err_o` low.
- R6: A present record whose index is above N_LOG is handled as R5, and `fuse_err_o` goes high.
- R7: For a logical ID L below N_LOG, `l2p_ok_o` is high and `l2p_phys_o` is L when L is below the disabled index, and L+1 otherwise.
- R8: For a logical ID of N_LOG or above, `l2p_ok_o` is low and `l2p_phys_o` is 0.
- R9: For a physical index P in 0..N_LOG other than the disabled one, `p2l_ok_o` is high and `p2l_log_o` is P when P is below the disabled index, and P-1 when it is above.
- R10: For the disabled index, or for any P above N_LOG, `p2l_ok_o` is low and `p2l_log_o` is 0.
- R11: Until `load_done_o` rises, both ok flags stay low and all enables stay low, even partway through a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_bit_i | input | 1 | Serial defect-record bit |
| fuse_vld_i | input | 1 | Strobe; `fuse_bit_i` is taken on this edge |
| load_done_o | output | 1 | Record complete, mapping in force |
| fuse_err_o | output | 1 | Present record named an out-of-range index |
| core_en_o | output | N_LOG+1 | One enable per physical core |
| l2p_lidx_i | input | IDX_W | Logical ID to translate |
| l2p_ok_o | output | 1 | Logical ID maps to a live core |
| l2p_phys_o | output | IDX_W | Physical index for `l2p_lidx_i` |
| p2l_pidx_i | input | IDX_W | Physical index to translate |
| p2l_ok_o | output | 1 | Physical index is a live core |
| p2l_log_o | output | IDX_W | Logical ID for `p2l_pidx_i` |

## Verification
The checker enforces several rules on every cycle. Nothing is enabled and nothing translates before loading ends. Exactly N_LOG enables are set afterward. Every translated result names an enabled core and differs from its query by zero or one. The loaded state stays frozen after loading ends, and the error flag never rises before done. Only the bench's scenarios can show that the right core was chosen. These are its sweep over every present index from 0 to 31, plus absent records whose index bits vary. They also include the exact strobe on which done rises and full tables for both lookups against the arithmetic rule.

// File: rtl/redun_pkg.sv
package redun_pkg;
    // default geometry: 16 compute + 1 service core visible, plus one spare
    localparam int DEF_N_LOG = 17;
    localparam int DEF_IDX_W = 5;
endpackage

// File: rtl/redun_fuse_loader.sv
module redun_fuse_loader #(
    parameter int N_LOG = redun_pkg::DEF_N_LOG,
    parameter int IDX_W = redun_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_bit_i,
    input  logic             fuse_vld_i,
    output logic             done_o,
    output logic             err_o,
    output logic [IDX_W-1:0] dead_o
);
    localparam int REC_W = IDX_W + 1;
    localparam int CNT_W = $clog2(REC_W + 1);
    localparam logic [IDX_W-1:0] SPARE_IDX = IDX_W'(N_LOG);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(REC_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [REC_W-1:0] sh;
        logic             done;
        logic             err;
        logic [IDX_W-1:0] dead;
    } ld_state_t;

    ld_state_t st_q, st_d;
    logic [REC_W-1:0] rec_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        st_d  = st_q;
        rec_d = {fuse_bit_i, st_q.sh[REC_W-1:1]};
        idx_d = rec_d[REC_W-1:1];
        if (fuse_vld_i && !st_q.done) begin
            st_d.sh  = rec_d;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_CNT) begin
                st_d.done = 1'b1;
                if (!rec_d[0]) begin
                    st_d.dead = SPARE_IDX;
                    st_d.err  = 1'b0;
                end else if (idx_d > SPARE_IDX) begin
                    st_d.dead = SPARE_IDX;
                    st_d.err  = 1'b1;
                end else begin
                    st_d.dead = idx_d;
                    st_d.err  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign err_o  = st_q.err;
    assign dead_o = st_q.dead;
endmodule

// File: rtl/redun_l2p.sv
module redun_l2p #(
    parameter int N_LOG = redun_pkg::DEF_N_LOG,
    parameter int IDX_W = redun_pkg::DEF_IDX_W
) (
    input  logic             done_i,
    input  logic [IDX_W-1:0] dead_i,
    input  logic [IDX_W-1:0] lidx_i,
    output logic             ok_o,
    output logic [IDX_W-1:0] phys_o
);
    localparam logic [IDX_W-1:0] LOG_LIM = IDX_W'(N_LOG);

    always_comb begin
        ok_o   = done_i && (lidx_i < LOG_LIM);
        phys_o = '0;
        if (ok_o) begin
            phys_o = (lidx_i >= dead_i) ? lidx_i + IDX_W'(1) : lidx_i;
        end
    end
endmodule

// File: rtl/redun_p2l.sv
module redun_p2l #(
    parameter int N_LOG = redun_pkg::DEF_N_LOG,
    parameter int IDX_W = redun_pkg::DEF_IDX_W
) (
    input  logic             done_i,
    input  logic [IDX_W-1:0] dead_i,
    input  logic [IDX_W-1:0] pidx_i,
    output logic             ok_o,
    output logic [IDX_W-1:0] log_o
);
    localparam logic [IDX_W-1:0] SPARE_IDX = IDX_W'(N_LOG);

    always_comb begin
        ok_o  = done_i && (pidx_i <= SPARE_IDX) && (pidx_i != dead_i);
        log_o = '0;
        if (ok_o) begin
            log_o = (pidx_i > dead_i) ? pidx_i - IDX_W'(1) : pidx_i;
        end
    end
endmodule

// File: rtl/redun_remap.sv
module redun_remap #(
    parameter int N_LOG = redun_pkg::DEF_N_LOG,
    parameter int IDX_W = redun_pkg::DEF_IDX_W,
    localparam int N_PHYS = N_LOG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_bit_i,
    input  logic              fuse_vld_i,
    output logic              load_done_o,
    output logic              fuse_err_o,
    output logic [N_PHYS-1:0] core_en_o,
    input  logic [IDX_W-1:0]  l2p_lidx_i,
    output logic              l2p_ok_o,
    output logic [IDX_W-1:0]  l2p_phys_o,
    input  logic [IDX_W-1:0]  p2l_pidx_i,
    output logic              p2l_ok_o,
    output logic [IDX_W-1:0]  p2l_log_o
);
    logic             done_w;
    logic [IDX_W-1:0] dead_w;

    redun_fuse_loader #(.N_LOG(N_LOG), .IDX_W(IDX_W)) loader_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fuse_bit_i (fuse_bit_i),
        .fuse_vld_i (fuse_vld_i),
        .done_o     (done_w),
        .err_o      (fuse_err_o),
        .dead_o     (dead_w)
    );

    redun_l2p #(.N_LOG(N_LOG), .IDX_W(IDX_W)) l2p_i (
        .done_i (done_w),
        .dead_i (dead_w),
        .lidx_i (l2p_lidx_i),
        .ok_o   (l2p_ok_o),
        .phys_o (l2p_phys_o)
    );

    redun_p2l #(.N_LOG(N_LOG), .IDX_W(IDX_W)) p2l_i (
        .done_i (done_w),
        .dead_i (dead_w),
        .pidx_i (p2l_pidx_i),
        .ok_o   (p2l_ok_o),
        .log_o  (p2l_log_o)
    );

    for (genvar g = 0; g < N_PHYS; g++) begin : g_en
        assign core_en_o[g] = done_w && (dead_w != IDX_W'(g));
    end

    assign load_done_o = done_w;
endmodule

// File: rtl/redun_remap_chk.sv
module redun_remap_chk #(
    parameter int N_LOG = redun_pkg::DEF_N_LOG,
    parameter int IDX_W = redun_pkg::DEF_IDX_W,
    localparam int N_PHYS = N_LOG + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_done_o,
    input logic              fuse_err_o,
    input logic [N_PHYS-1:0] core_en_o,
    input logic [IDX_W-1:0]  l2p_lidx_i,
    input logic              l2p_ok_o,
    input logic [IDX_W-1:0]  l2p_phys_o,
    input logic [IDX_W-1:0]  p2l_pidx_i,
    input logic              p2l_ok_o,
    input logic [IDX_W-1:0]  p2l_log_o
);
    localparam logic [N_PHYS-1:0] ONE = N_PHYS'(1);

    a_r11_idle_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done_o |-> (core_en_o == '0) && !l2p_ok_o && !p2l_ok_o);

    a_r4_single_core_off: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |-> ($countones(core_en_o) == N_LOG));

    a_r3_frozen_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |=> load_done_o && $stable(core_en_o) && $stable(fuse_err_o));

    a_r7_l2p_hits_live_core: assert property (@(posedge clk) disable iff (!rst_n)
        l2p_ok_o |-> (((core_en_o >> l2p_phys_o) & ONE) != '0));

    a_r7_l2p_shift_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        l2p_ok_o |-> (l2p_phys_o == l2p_lidx_i) || (l2p_phys_o == l2p_lidx_i + IDX_W'(1)));

    a_r9_p2l_from_live_core: assert property (@(posedge clk) disable iff (!rst_n)
        p2l_ok_o |-> (((core_en_o >> p2l_pidx_i) & ONE) != '0) && (p2l_log_o < IDX_W'(N_LOG)));

    a_r6_err_only_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_err_o |-> load_done_o);
endmodule

bind redun_remap redun_remap_chk #(.N_LOG(N_LOG), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_done_o (load_done_o),
    .fuse_err_o  (fuse_err_o),
    .core_en_o   (core_en_o),
    .l2p_lidx_i  (l2p_lidx_i),
    .l2p_ok_o    (l2p_ok_o),
    .l2p_phys_o  (l2p_phys_o),
    .p2l_pidx_i  (p2l_pidx_i),
    .p2l_ok_o    (p2l_ok_o),
    .p2l_log_o   (p2l_log_o)
);

// File: tb/redun_remap_tb_top.sv
`timescale 1ns/1ps
module redun_remap_tb_top;
    localparam int N_LOG  = 17;
    localparam int IDX_W  = 5;
    localparam int N_PHYS = N_LOG + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fuse_bit = 1'b0, fuse_vld = 1'b0;
    logic load_done, fuse_err, l2p_ok, p2l_ok;
    logic [N_PHYS-1:0] core_en;
    logic [IDX_W-1:0] l2p_lidx = '0, l2p_phys, p2l_pidx = '0, p2l_log;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    redun_remap #(.N_LOG(N_LOG), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fuse_bit_i(fuse_bit), .fuse_vld_i(fuse_vld),
        .load_done_o(load_done), .fuse_err_o(fuse_err), .core_en_o(core_en),
        .l2p_lidx_i(l2p_lidx), .l2p_ok_o(l2p_ok), .l2p_phys_o(l2p_phys),
        .p2l_pidx_i(p2l_pidx), .p2l_ok_o(p2l_ok), .p2l_log_o(p2l_log)
    );

    task automatic check(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // record: bit0 = present flag, bits 5:1 = index; sent bit0 first
    task automatic send_record(logic [5:0] rec, bit check_progress);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (check_progress && i == 3) begin
                l2p_lidx = 5'd0; p2l_pidx = 5'd0; #0.1;
                check("R11 l2p_ok mid-record", l2p_ok, 0);
                check("R11 p2l_ok mid-record", p2l_ok, 0);
                check("R11 core_en mid-record", core_en, 0);
            end
            if (check_progress && i == 5) check("R2 done after five strobes", load_done, 0);
            fuse_bit = rec[i];
            fuse_vld = 1'b1;
        end
        @(negedge clk);
        fuse_vld = 1'b0;
        fuse_bit = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 done in reset", load_done, 0);
        check("R1 err in reset", fuse_err, 0);
        check("R1 core_en in reset", core_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        l2p_lidx = 5'd3; p2l_pidx = 5'd3; #0.1;
        check("R1 done after reset", load_done, 0);
        check("R1 l2p_ok after reset", l2p_ok, 0);
        check("R1 l2p_phys after reset", l2p_phys, 0);
        check("R1 p2l_ok after reset", p2l_ok, 0);
        check("R1 p2l_log after reset", p2l_log, 0);
    endtask

    task automatic verify_map(int dead, bit err_exp, string tag);
        logic [N_PHYS-1:0] en_exp;
        en_exp = '1;
        en_exp[dead] = 1'b0;
        check({tag, " core_en"}, core_en, en_exp);
        check({tag, " fuse_err"}, fuse_err, err_exp);
        for (int l = 0; l < 32; l++) begin
            l2p_lidx = 5'(l); #0.1;
            if (l < N_LOG) begin
                check("R7 l2p_ok", l2p_ok, 1);
                check("R7 l2p_phys", l2p_phys, (l >= dead) ? l + 1 : l);
            end else begin
                check("R8 l2p_ok", l2p_ok, 0);
                check("R8 l2p_phys", l2p_phys, 0);
            end
        end
        for (int p = 0; p < 32; p++) begin
            p2l_pidx = 5'(p); #0.1;
            if (p <= N_LOG && p != dead) begin
                check("R9 p2l_ok", p2l_ok, 1);
                check("R9 p2l_log", p2l_log, (p > dead) ? p - 1 : p);
            end else begin
                check("R10 p2l_ok", p2l_ok, 0);
                check("R10 p2l_log", p2l_log, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // present records with every index 0..31
        for (int idx = 0; idx < 32; idx++) begin
            int dead;
            bit err;
            do_reset();
            send_record({5'(idx), 1'b1}, 1);
            check("R2 done after sixth strobe", load_done, 1);
            dead = (idx <= N_LOG) ? idx : N_LOG;
            err  = (idx > N_LOG);
            verify_map(dead, err, (idx <= N_LOG) ? "R4" : "R6");
            // late strobes must change nothing
            send_record({5'((idx + 7) % 18), 1'b1}, 0);
            send_record(6'b111111, 0);
            verify_map(dead, err, "R3");
        end
        // absent records, varied index bits
        for (int k = 0; k < 4; k++) begin
            logic [4:0] junk;
            junk = (k == 0) ? 5'd0 : (k == 1) ? 5'd9 : (k == 2) ? 5'd17 : 5'd31;
            do_reset();
            send_record({junk, 1'b0}, 1);
            check("R2 done after sixth strobe", load_done, 1);
            verify_map(N_LOG, 0, "R5");
        end
        summary();
    end
endmodule